// File: doc/BRIEF.md
# Floating-Point Stack Escape Decoder

This block classifies one floating-point stack instruction from its escape byte (0xD8 to 0xDF) and the ModR/M byte that follows it. It emits a registered control bundle for the execution stage. The bundle names the operation, where the second operand comes from, where the result lands, which stack slot is addressed, how many pops follow, whether a push happens, which built-in constant to load, which status-control action to take, and whether the form is illegal. Address generation, the arithmetic itself and instruction fetch belong to other units.

A fetch stage presents the two bytes with a one-cycle `in_valid` strobe. One clock later the bundle appears with `out_valid` high. Between strobes the bundle keeps its last value.

Top module: `fpu_esc_decoder`

## Requirements
- R1: A ModR/M mode field of 2'b11 selects the register form. In that form, stack-operand operations (arithmetic, compare, copy-load, exchange) report `src_sel`=1 (stack register) and `stk_idx` equal to ModR/M bits [2:0]. Every memory form, and every form with no stack operand, reports `stk_idx`=0. `dst_sel` codes: 0 none, 1 ST(0), 2 ST(i), 3 memory.
- R2: For escape 0xD8, reg field values 0..7 give `op_class` add(1), multiply(2), compare(3), compare with one pop(3, `pop_cnt`=1), subtract(4, ST(0)−operand), reverse subtract(5, operand−ST(0)), divide(6) and reverse divide(7). Arithmetic writes ST(0). Compares have `dst_sel`=0. Other `op_class` codes: 0 none, 8 load, 9 store, 10 exchange, 11 constant, 12 control.
- R3: In the 0xDC register form, arithmetic writes ST(i), and subtract/divide are reversed against 0xD8. Reg 4 gives code 5 (ST(i)−ST(0)), reg 5 gives code 4, reg 6 gives code 7 and reg 7 gives code 6.
- R4: The 0xDE register form matches 0xDC plus one pop. The single byte pair DE D9 is a compare of ST(0) with ST(1) (`stk_idx`=1) followed by two pops. Other 0xDE register forms with reg 2 or 3 are illegal.
- R5: 0xD9 register form: reg 0 pushes a copy of ST(i) (load, push=1, dst ST(0)), and reg 1 exchanges ST(0) with ST(i) (code 10, dst ST(i)). Reg 5 with rm 0..6 pushes a constant (code 11, `const_sel`=rm, in order 1, log2 10, log2 e, pi, log10 2, ln 2, 0). Rm 7 is illegal.
- R6: DB E2 clears the status word (`ctl_act`=1), DB E3 reinitialises the unit (`ctl_act`=2), and DF E0 copies the status word into the low accumulator half (`ctl_act`=3). All three report `op_class`=12 and `dst_sel`=0.
- R7: Memory arithmetic follows the R2 mapping with no reversal and result in ST(0). The operand format depends on the escape: 0xD8 float32, 0xDA int32, 0xDC float64, 0xDE int16. `src_sel` codes: 2 int16, 3 int32, 4 int64, 5 float32, 6 float64.
- R8: Memory reg 0/2/3 are load (push), store and store-with-pop: float32 under 0xD9, float64 under 0xDD, int32 under 0xDB. 0xDF reg 5 loads int64 and 0xDF reg 7 stores int64 and pops. A store has `dst_sel`=3, and a push never comes with a pop.
- R9: Every other form, including any first byte outside 0xD8..0xDF, raises `trap`. All other bundle fields are then zero.
- R10: `out_valid` goes high exactly one cycle after each `in_valid` cycle. Without a strobe, `out_valid` is low and the bundle holds its last value. After reset, `out_valid`, `trap` and all fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction bytes valid this cycle |
| esc_byte | input | 8 | First opcode byte |
| modrm | input | 8 | ModR/M byte |
| out_valid | output | 1 | Bundle updated this cycle |
| op_class | output | 4 | Operation code (R2) |
| src_sel | output | 3 | Second operand source (R1, R7) |
| dst_sel | output | 2 | Result destination (R1) |
| stk_idx | output | 3 | Stack slot i |
| pop_cnt | output | 2 | Pops after the operation |
| push | output | 1 | Push before the write |
| const_sel | output | 3 | Constant selector (R5) |
| ctl_act | output | 2 | Status-control action (R6) |
| trap | output | 1 | Illegal form |

## Verification
The assertions that refer to the previous cycle's `esc_byte` and `modrm` assume those inputs are steady during each strobe cycle and are sampled only when `in_valid` is high. The stimulus changes them only at the falling clock edge, and together with `in_valid`. The checks on pop and push relationships assume the decode is the only source of those fields. Stimulus covers every escape byte, both ModR/M forms, gaps between strobes and non-escape bytes, so each property sees both legal and trapping forms.

// File: rtl/fpu_esc_pkg.sv
package fpu_esc_pkg;

  typedef enum logic [3:0] {
    OP_NONE = 4'd0, OP_ADD = 4'd1, OP_MUL = 4'd2, OP_CMP = 4'd3,
    OP_SUB = 4'd4, OP_SUBR = 4'd5, OP_DIV = 4'd6, OP_DIVR = 4'd7,
    OP_LOAD = 4'd8, OP_STORE = 4'd9, OP_XCHG = 4'd10, OP_CONST = 4'd11,
    OP_CTRL = 4'd12
  } op_e;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0, SRC_STI = 3'd1, SRC_I16 = 3'd2, SRC_I32 = 3'd3,
    SRC_I64 = 3'd4, SRC_F32 = 3'd5, SRC_F64 = 3'd6
  } src_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0, DST_ST0 = 2'd1, DST_STI = 2'd2, DST_MEM = 2'd3
  } dst_e;

  typedef enum logic [1:0] {
    CTL_NONE = 2'd0, CTL_CLR_SW = 2'd1, CTL_REINIT = 2'd2, CTL_SW_ACC = 2'd3
  } ctl_e;

  typedef struct packed {
    op_e        op;
    src_e       src;
    dst_e       dst;
    logic [2:0] idx;
    logic [1:0] pop;
    logic       push;
    logic [2:0] csel;
    ctl_e       ctl;
    logic       trap;
  } dec_t;

  // Operand A is always ST(0); operand B is the selected source.
  function automatic op_e arith_op(input logic [2:0] r, input logic rev);
    case (r)
      3'd0:    return OP_ADD;
      3'd1:    return OP_MUL;
      3'd2,
      3'd3:    return OP_CMP;
      3'd4:    return rev ? OP_SUBR : OP_SUB;
      3'd5:    return rev ? OP_SUB : OP_SUBR;
      3'd6:    return rev ? OP_DIVR : OP_DIV;
      default: return rev ? OP_DIV : OP_DIVR;
    endcase
  endfunction

  function automatic dec_t trap_bundle();
    dec_t b = '0;
    b.trap = 1'b1;
    return b;
  endfunction

  function automatic dec_t arith_bundle(input logic [2:0] r, input src_e s,
                                        input logic rev, input dst_e d,
                                        input logic [2:0] idx,
                                        input logic [1:0] pop_base);
    dec_t b = '0;
    b.op  = arith_op(r, rev);
    b.src = s;
    b.idx = idx;
    b.dst = (r == 3'd2 || r == 3'd3) ? DST_NONE : d;
    b.pop = pop_base + {1'b0, (r == 3'd3)};
    return b;
  endfunction

  function automatic dec_t xfer_bundle(input logic [2:0] r, input src_e fmt);
    dec_t b = '0;
    case (r)
      3'd0: begin b.op = OP_LOAD;  b.src = fmt; b.dst = DST_ST0; b.push = 1'b1; end
      3'd2: begin b.op = OP_STORE; b.src = fmt; b.dst = DST_MEM; end
      3'd3: begin b.op = OP_STORE; b.src = fmt; b.dst = DST_MEM; b.pop = 2'd1; end
      default: b = trap_bundle();
    endcase
    return b;
  endfunction

endpackage

// File: rtl/fpu_esc_regform.sv
module fpu_esc_regform
  import fpu_esc_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic [2:0]       esc_lo,
  input  logic [2:0]       reg_f,
  input  logic [IDX_W-1:0] rm_f,
  output dec_t             dec
);
  localparam logic [IDX_W-1:0] CONST_LAST = IDX_W'(6);

  always_comb begin
    dec = trap_bundle();
    case (esc_lo)
      3'd0: dec = arith_bundle(reg_f, SRC_STI, 1'b0, DST_ST0, rm_f, 2'd0);
      3'd4: dec = arith_bundle(reg_f, SRC_STI, 1'b1, DST_STI, rm_f, 2'd0);
      3'd6: begin
        if (reg_f == 3'd3 && rm_f == IDX_W'(1)) begin
          dec     = '0;
          dec.op  = OP_CMP;
          dec.src = SRC_STI;
          dec.idx = rm_f;
          dec.pop = 2'd2;
        end else if (reg_f != 3'd2 && reg_f != 3'd3) begin
          dec = arith_bundle(reg_f, SRC_STI, 1'b1, DST_STI, rm_f, 2'd1);
        end
      end
      3'd1: begin
        if (reg_f == 3'd0) begin
          dec      = '0;
          dec.op   = OP_LOAD;
          dec.src  = SRC_STI;
          dec.dst  = DST_ST0;
          dec.idx  = rm_f;
          dec.push = 1'b1;
        end else if (reg_f == 3'd1) begin
          dec     = '0;
          dec.op  = OP_XCHG;
          dec.src = SRC_STI;
          dec.dst = DST_STI;
          dec.idx = rm_f;
        end else if (reg_f == 3'd5 && rm_f <= CONST_LAST) begin
          dec      = '0;
          dec.op   = OP_CONST;
          dec.dst  = DST_ST0;
          dec.push = 1'b1;
          dec.csel = rm_f;
        end
      end
      3'd3: begin
        if (reg_f == 3'd4 && rm_f == IDX_W'(2)) begin
          dec = '0; dec.op = OP_CTRL; dec.ctl = CTL_CLR_SW;
        end else if (reg_f == 3'd4 && rm_f == IDX_W'(3)) begin
          dec = '0; dec.op = OP_CTRL; dec.ctl = CTL_REINIT;
        end
      end
      3'd7: begin
        if (reg_f == 3'd4 && rm_f == IDX_W'(0)) begin
          dec = '0; dec.op = OP_CTRL; dec.ctl = CTL_SW_ACC;
        end
      end
      default: dec = trap_bundle();
    endcase
  end
endmodule

// File: rtl/fpu_esc_memform.sv
module fpu_esc_memform
  import fpu_esc_pkg::*;
(
  input  logic [2:0] esc_lo,
  input  logic [2:0] reg_f,
  output dec_t       dec
);
  always_comb begin
    dec = trap_bundle();
    case (esc_lo)
      3'd0: dec = arith_bundle(reg_f, SRC_F32, 1'b0, DST_ST0, 3'd0, 2'd0);
      3'd2: dec = arith_bundle(reg_f, SRC_I32, 1'b0, DST_ST0, 3'd0, 2'd0);
      3'd4: dec = arith_bundle(reg_f, SRC_F64, 1'b0, DST_ST0, 3'd0, 2'd0);
      3'd6: dec = arith_bundle(reg_f, SRC_I16, 1'b0, DST_ST0, 3'd0, 2'd0);
      3'd1: dec = xfer_bundle(reg_f, SRC_F32);
      3'd5: dec = xfer_bundle(reg_f, SRC_F64);
      3'd3: dec = xfer_bundle(reg_f, SRC_I32);
      default: begin
        if (reg_f == 3'd5)      dec = xfer_bundle(3'd0, SRC_I64);
        else if (reg_f == 3'd7) dec = xfer_bundle(3'd3, SRC_I64);
      end
    endcase
  end
endmodule

// File: rtl/fpu_esc_decoder.sv
module fpu_esc_decoder
  import fpu_esc_pkg::*;
#(
  parameter logic [4:0] ESC_PREFIX = 5'b11011
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] esc_byte,
  input  logic [7:0] modrm,
  output logic       out_valid,
  output logic [3:0] op_class,
  output logic [2:0] src_sel,
  output logic [1:0] dst_sel,
  output logic [2:0] stk_idx,
  output logic [1:0] pop_cnt,
  output logic       push,
  output logic [2:0] const_sel,
  output logic [1:0] ctl_act,
  output logic       trap
);
  localparam int IDX_W = 3;

  logic is_esc, reg_form;
  dec_t d_reg, d_mem, d_next, d_q;
  logic vld_q;

  assign is_esc   = (esc_byte[7:3] == ESC_PREFIX);
  assign reg_form = (modrm[7:6] == 2'b11);

  fpu_esc_regform #(.IDX_W(IDX_W)) u_reg (
    .esc_lo (esc_byte[2:0]),
    .reg_f  (modrm[5:3]),
    .rm_f   (modrm[IDX_W-1:0]),
    .dec    (d_reg)
  );

  fpu_esc_memform u_mem (
    .esc_lo (esc_byte[2:0]),
    .reg_f  (modrm[5:3]),
    .dec    (d_mem)
  );

  always_comb begin
    if (!is_esc)       d_next = trap_bundle();
    else if (reg_form) d_next = d_reg;
    else               d_next = d_mem;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      d_q   <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) d_q <= d_next;
    end
  end

  assign out_valid = vld_q;
  assign op_class  = d_q.op;
  assign src_sel   = d_q.src;
  assign dst_sel   = d_q.dst;
  assign stk_idx   = d_q.idx;
  assign pop_cnt   = d_q.pop;
  assign push      = d_q.push;
  assign const_sel = d_q.csel;
  assign ctl_act   = d_q.ctl;
  assign trap      = d_q.trap;
endmodule

// File: rtl/fpu_esc_decoder_chk.sv
module fpu_esc_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic [7:0] esc_byte,
  input logic [7:0] modrm,
  input logic       out_valid,
  input logic [3:0] op_class,
  input logic [2:0] src_sel,
  input logic [1:0] dst_sel,
  input logic [2:0] stk_idx,
  input logic [1:0] pop_cnt,
  input logic       push,
  input logic [2:0] const_sel,
  input logic [1:0] ctl_act,
  input logic       trap
);
  AST_TRAP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (out_valid && trap) |-> (op_class == 4'd0 && src_sel == 3'd0 && dst_sel == 2'd0 &&
                             pop_cnt == 2'd0 && !push && ctl_act == 2'd0)); // R9

  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R10

  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(op_class) && $stable(trap) && $stable(pop_cnt))); // R10

  AST_PUSH_NO_POP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && push) |-> (pop_cnt == 2'd0)); // R8

  AST_DOUBLE_POP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && pop_cnt == 2'd2) |-> (op_class == 4'd3 && stk_idx == 3'd1 && src_sel == 3'd1)); // R4

  AST_D8_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(esc_byte) == 8'hD8) |-> (!trap && pop_cnt <= 2'd1)); // R2

  AST_CONST_PUSH: assert property (@(posedge clk) disable iff (rst)
    (out_valid && op_class == 4'd11) |-> (push && dst_sel == 2'd1 && const_sel != 3'd7)); // R5

  AST_MEM_IDX: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !trap && $past(modrm[7:6]) != 2'b11) |-> (stk_idx == 3'd0 && src_sel != 3'd1)); // R1
endmodule

bind fpu_esc_decoder fpu_esc_decoder_chk u_chk (.*);

// File: tb/sim_fpu_esc_decoder.sv
module sim_fpu_esc_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] esc_byte = 8'h00;
  logic [7:0] modrm = 8'h00;
  logic       out_valid, push, trap;
  logic [3:0] op_class;
  logic [2:0] src_sel, stk_idx, const_sel;
  logic [1:0] dst_sel, pop_cnt, ctl_act;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [20:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  fpu_esc_decoder u0 (.*);

  function automatic logic [20:0] ex(int op, int src, int dst, int idx, int pop,
                                     int ps, int cs, int ctl, int tr);
    return {4'(op), 3'(src), 2'(dst), 3'(idx), 2'(pop), 1'(ps), 3'(cs), 2'(ctl), 1'(tr)};
  endfunction

  function automatic logic [20:0] actual();
    return {op_class, src_sel, dst_sel, stk_idx, pop_cnt, push, const_sel, ctl_act, trap};
  endfunction

  localparam logic [20:0] TRP = 21'h1;

  task automatic send(input logic [7:0] e, input logic [7:0] m,
                      input logic [20:0] x, input string tag);
    @(negedge clk);
    esc_byte = e; modrm = m; in_valid = 1'b1;
    exp_q.push_back(x);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst && out_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected out_valid act=%h exp=none", actual());
        end else begin
          logic [20:0] x;
          string t;
          x = exp_q.pop_front();
          t = tag_q.pop_front();
          if (actual() !== x) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", t, actual(), x);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    checks++;
    if (out_valid !== 1'b0 || actual() !== 21'h0) begin
      errors++;
      $display("FAIL R10 reset act=%b/%h exp=0/0", out_valid, actual());
    end

    // R1 R2: 0xD8 register forms
    send(8'hD8, 8'hC3, ex(1,1,1,3,0,0,0,0,0), "R1 R2 D8 add st3");
    send(8'hD8, 8'hE9, ex(5,1,1,1,0,0,0,0,0), "R2 D8 subr st1");
    send(8'hD8, 8'hD2, ex(3,1,0,2,0,0,0,0,0), "R2 D8 cmp");
    send(8'hD8, 8'hDA, ex(3,1,0,2,1,0,0,0,0), "R2 D8 cmp pop");
    idle(1);
    // R3
    send(8'hDC, 8'hE2, ex(5,1,2,2,0,0,0,0,0), "R3 DC reg4 reversed");
    send(8'hDC, 8'hFB, ex(6,1,2,3,0,0,0,0,0), "R3 DC reg7 div");
    send(8'hDC, 8'hC9, ex(2,1,2,1,0,0,0,0,0), "R3 DC mul");
    // R4
    send(8'hDE, 8'hC1, ex(1,1,2,1,1,0,0,0,0), "R4 DE add pop");
    send(8'hDE, 8'hD9, ex(3,1,0,1,2,0,0,0,0), "R4 DE D9 double pop");
    send(8'hDE, 8'hD1, TRP,                   "R4 DE reg2 trap");
    send(8'hDE, 8'hF9, ex(6,1,2,1,1,0,0,0,0), "R4 DE reg7 pop");
    // R5
    send(8'hD9, 8'hC2, ex(8,1,1,2,0,1,0,0,0), "R5 D9 copy push");
    send(8'hD9, 8'hCD, ex(10,1,2,5,0,0,0,0,0), "R5 D9 exchange");
    send(8'hD9, 8'hEB, ex(11,0,1,0,0,1,3,0,0), "R5 const pi");
    send(8'hD9, 8'hEE, ex(11,0,1,0,0,1,6,0,0), "R5 const zero");
    send(8'hD9, 8'hEF, TRP,                    "R5 const rm7 trap");
    idle(2);
    // R6
    send(8'hDB, 8'hE2, ex(12,0,0,0,0,0,0,1,0), "R6 clear status");
    send(8'hDB, 8'hE3, ex(12,0,0,0,0,0,0,2,0), "R6 reinit");
    send(8'hDF, 8'hE0, ex(12,0,0,0,0,0,0,3,0), "R6 status to acc");
    send(8'hDF, 8'hE1, TRP,                    "R6 DF E1 trap");
    // R7
    send(8'hD8, 8'h20, ex(4,5,1,0,0,0,0,0,0), "R7 D8 mem sub f32");
    send(8'hDA, 8'h70, ex(6,3,1,0,0,0,0,0,0), "R7 DA mem div i32");
    send(8'hDC, 8'hA8, ex(5,6,1,0,0,0,0,0,0), "R7 DC mem subr f64");
    send(8'hDE, 8'h18, ex(3,2,0,0,1,0,0,0,0), "R7 DE mem cmp pop i16");
    // R8
    send(8'hD9, 8'h00, ex(8,5,1,0,0,1,0,0,0), "R8 load f32");
    send(8'hD9, 8'h18, ex(9,5,3,0,1,0,0,0,0), "R8 store pop f32");
    send(8'hDD, 8'h10, ex(9,6,3,0,0,0,0,0,0), "R8 store f64");
    send(8'hDB, 8'h00, ex(8,3,1,0,0,1,0,0,0), "R8 load i32");
    send(8'hDB, 8'h1D, ex(9,3,3,0,1,0,0,0,0), "R8 store pop i32");
    send(8'hDF, 8'h28, ex(8,4,1,0,0,1,0,0,0), "R8 load i64");
    send(8'hDF, 8'h38, ex(9,4,3,0,1,0,0,0,0), "R8 store pop i64");
    // R9
    send(8'hDF, 8'h00, TRP, "R9 DF mem reg0");
    send(8'hDA, 8'hC0, TRP, "R9 DA reg form");
    send(8'hDD, 8'hC0, TRP, "R9 DD reg form");
    send(8'hD9, 8'h08, TRP, "R9 D9 mem reg1");
    send(8'h90, 8'hC0, TRP, "R9 non-escape byte");
    // R10: hold after the last strobe
    send(8'hD8, 8'hC3, ex(1,1,1,3,0,0,0,0,0), "R10 last strobe");
    idle(4);
    #1;
    checks++;
    if (out_valid !== 1'b0 || actual() !== ex(1,1,1,3,0,0,0,0,0)) begin
      errors++;
      $display("FAIL R10 hold act=%b/%h exp=0/%h", out_valid, actual(), ex(1,1,1,3,0,0,0,0,0));
    end
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 missing outputs act=%0d exp=0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule